// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Hazard Unit

This block resolves data hazards for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It reads register numbers and a few control flags from the decode, execute, memory and writeback stages. From these it chooses, for each of the two execute-stage ALU operands, whether to use the register-file value, the memory-stage ALU result or the writeback result.

It also drives a store-data forwarding select for the memory stage. When a store in the memory stage needs a register that the writeback stage is writing in the same cycle, the writeback value replaces the store data on its way to data memory. The same path lets a load followed at once by a store of the loaded register run without a stall.

A load in execute whose destination feeds the decode-stage instruction as an address or ALU source raises a one-cycle stall. That stall holds the fetch and decode registers and turns the execute register into a bubble. The pipeline registers, register file, ALU and data memory sit outside the block.

Top module: `hzd_unit`

## Requirements
- R1: Each execute operand select (`fwd_sel_a` for `ex_rs`, `fwd_sel_b` for `ex_rt`) is 2'b10 when the memory stage writes a register (`mem_wr_reg`=1), is not a load, and its destination equals that operand's register number. The code 2'b11 never appears.
- R2: When R1 does not apply and the writeback stage writes a register (`wb_wr_reg`=1) whose destination equals the operand's register number, the select is 2'b01. Otherwise it is 2'b00 (register-file value).
- R3: When both the memory and writeback stages qualify for the same operand, the select is 2'b10: the memory stage wins.
- R4: A register number of zero never produces a forward of any kind, a store-data forward or a stall, whatever the write enables.
- R5: `st_fwd_sel` is 1 exactly when `wb_wr_reg`=1, `mem_is_store`=1, and `wb_dst` equals `mem_rt` and is nonzero.
- R6: When `ex_is_load`=1 and a nonzero `ex_dst` equals `dec_rs`, or equals `dec_rt` of a non-store decode instruction, then `stall_fetch`, `stall_decode` and `flush_execute` are all 1. Otherwise all three are 0.
- R7: A decode-stage store (`dec_is_store`=1) whose only match with a loading execute instruction is its data register `dec_rt` does not stall.
- R8: A load in the memory stage is never selected as an execute-operand source (its ALU result is an address, not the loaded data). The operand falls back to the writeback match or to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | AW | First source register of the decode-stage instruction |
| dec_rt | input | AW | Second source register of the decode-stage instruction |
| dec_is_store | input | 1 | Decode-stage instruction is a store |
| ex_rs | input | AW | First source register of the execute-stage instruction |
| ex_rt | input | AW | Second source register of the execute-stage instruction |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| mem_wr_reg | input | 1 | Memory-stage instruction writes the register file |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_rt | input | AW | Store-data register carried into the memory stage |
| mem_is_store | input | 1 | Memory-stage instruction writes data memory |
| wb_dst | input | AW | Destination register of the writeback-stage instruction |
| wb_wr_reg | input | 1 | Writeback-stage instruction writes the register file |
| fwd_sel_a | output | 2 | Source select for execute operand A |
| fwd_sel_b | output | 2 | Source select for execute operand B |
| st_fwd_sel | output | 1 | Replace memory-stage store data with writeback value |
| stall_fetch | output | 1 | Hold the fetch register |
| stall_decode | output | 1 | Hold the decode register |
| flush_execute | output | 1 | Load a bubble into the execute register |

## Verification
Directed patterns cover each case on its own: a lone memory match, a lone writeback match, a double match, a memory-stage load, and a dependence through register zero. Together they separate the priority, the write-enable gating and the zero exclusion. Load-use patterns put the loaded register on the decode address source, on the data source of a store, and on the second source of a non-store, which tells the stall exemption apart from a missing stall. Store-data patterns vary the register match and each of the two enables one at a time. A stream of random register numbers drawn from a small range, so that matches are frequent, is checked against a reference model in the bench.

// File: rtl/hzd_pkg.sv
// Package: shared types for the hazard unit.
// Assumes a 2-bit operand select whose codes are fixed by the datapath mux.
package hzd_pkg;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WB      = 2'b01,
        SEL_MEM     = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/hzd_operand_fwd.sv
// Module: hzd_operand_fwd
// Picks the source of one execute-stage ALU operand. The memory stage has
// priority over writeback. A load in the memory stage is not a source, and
// register zero is never forwarded.
// Assumes the destination numbers are valid whenever the write enables are set.
module hzd_operand_fwd
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_reg,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_reg,
    output fwd_sel_e      sel
);

    logic src_nz;
    logic hit_mem;
    logic hit_wb;

    // Match detection for each producing stage.
    always_comb begin
        src_nz  = (src != '0);
        hit_mem = src_nz && mem_wr_reg && !mem_is_load && (mem_dst == src);
        hit_wb  = src_nz && wb_wr_reg && (wb_dst == src);
    end

    // Priority select: the younger result comes first.
    always_comb begin
        if (hit_mem)     sel = SEL_MEM;
        else if (hit_wb) sel = SEL_WB;
        else             sel = SEL_REGFILE;
    end

endmodule

// File: rtl/hzd_store_fwd.sv
// Module: hzd_store_fwd
// Detects that the store in the memory stage needs the register the
// writeback stage is writing in the same cycle.
// Assumes mem_rt is carried through the memory pipeline register.
module hzd_store_fwd #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] mem_rt,
    input  logic          mem_is_store,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_reg,
    output logic          st_fwd
);

    // Qualified register match between writeback and store data.
    always_comb begin
        st_fwd = wb_wr_reg && mem_is_store && (wb_dst != '0) && (wb_dst == mem_rt);
    end

endmodule

// File: rtl/hzd_load_stall.sv
// Module: hzd_load_stall
// Raises a one-cycle load-use stall. The store-data source of a decode-stage
// store is exempt, because the store-data forward covers it one stage later.
// Assumes ex_dst holds the load target when ex_is_load is set.
module hzd_load_stall #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] dec_rs,
    input  logic [AW-1:0] dec_rt,
    input  logic          dec_is_store,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_is_load,
    output logic          stall
);

    logic dst_nz;
    logic use_rs;
    logic use_rt;

    // Dependence of the decode instruction on the pending load.
    always_comb begin
        dst_nz = (ex_dst != '0);
        use_rs = (ex_dst == dec_rs);
        use_rt = (ex_dst == dec_rt) && !dec_is_store;
        stall  = ex_is_load && dst_nz && (use_rs || use_rt);
    end

endmodule

// File: rtl/hzd_unit.sv
// Module: hzd_unit (top)
// Combinational hazard resolution for a five-stage pipeline: operand
// forwarding selects, store-data forwarding and load-use stall and flush.
// Assumes the pipeline registers apply the stall and flush on the next edge.
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int AW      = 5,
    parameter int NUM_OPS = 2
) (
    input  logic [AW-1:0] dec_rs,
    input  logic [AW-1:0] dec_rt,
    input  logic          dec_is_store,
    input  logic [AW-1:0] ex_rs,
    input  logic [AW-1:0] ex_rt,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_reg,
    input  logic          mem_is_load,
    input  logic [AW-1:0] mem_rt,
    input  logic          mem_is_store,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_reg,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic          st_fwd_sel,
    output logic          stall_fetch,
    output logic          stall_decode,
    output logic          flush_execute
);

    localparam int SEL_W = $bits(fwd_sel_e);

    logic [AW-1:0] op_src [NUM_OPS];
    fwd_sel_e      op_sel [NUM_OPS];
    logic          st_fwd;
    logic          ld_stall;

    // Operand register numbers in select order: index 0 is A, index 1 is B.
    always_comb begin
        for (int i = 0; i < NUM_OPS; i++) op_src[i] = '0;
        op_src[0] = ex_rs;
        if (NUM_OPS > 1) op_src[1] = ex_rt;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_OPS; g++) begin : g_op
            hzd_operand_fwd #(.AW(AW)) u_fwd (
                .src        (op_src[g]),
                .mem_dst    (mem_dst),
                .mem_wr_reg (mem_wr_reg),
                .mem_is_load(mem_is_load),
                .wb_dst     (wb_dst),
                .wb_wr_reg  (wb_wr_reg),
                .sel        (op_sel[g])
            );
        end
    endgenerate

    hzd_store_fwd #(.AW(AW)) u_st (
        .mem_rt      (mem_rt),
        .mem_is_store(mem_is_store),
        .wb_dst      (wb_dst),
        .wb_wr_reg   (wb_wr_reg),
        .st_fwd      (st_fwd)
    );

    hzd_load_stall #(.AW(AW)) u_ld (
        .dec_rs      (dec_rs),
        .dec_rt      (dec_rt),
        .dec_is_store(dec_is_store),
        .ex_dst      (ex_dst),
        .ex_is_load  (ex_is_load),
        .stall       (ld_stall)
    );

    // Output drive: selects as raw codes, one stall fanned to three registers.
    always_comb begin
        fwd_sel_a     = SEL_W'(op_sel[0]);
        fwd_sel_b     = (NUM_OPS > 1) ? SEL_W'(op_sel[NUM_OPS-1]) : SEL_W'(SEL_REGFILE);
        st_fwd_sel    = st_fwd;
        stall_fetch   = ld_stall;
        stall_decode  = ld_stall;
        flush_execute = ld_stall;
    end

endmodule

// File: rtl/hzd_unit_chk.sv
// Module: hzd_unit_chk
// Property checker bound to hzd_unit. It relates the outputs to the stage
// inputs with immediate assertions, since the block holds no state.
module hzd_unit_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] dec_rs,
    input logic [AW-1:0] dec_rt,
    input logic          dec_is_store,
    input logic [AW-1:0] ex_rs,
    input logic [AW-1:0] ex_dst,
    input logic          ex_is_load,
    input logic          mem_wr_reg,
    input logic          mem_is_load,
    input logic          mem_is_store,
    input logic [AW-1:0] wb_dst,
    input logic          wb_wr_reg,
    input logic [1:0]    fwd_sel_a,
    input logic [1:0]    fwd_sel_b,
    input logic          st_fwd_sel,
    input logic          stall_fetch,
    input logic          stall_decode,
    input logic          flush_execute
);

    // Output consistency checks.
    always_comb begin
        p_sel_legal_r1: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11);
        p_mem_needs_wr_r1: assert (!(fwd_sel_a == 2'b10 || fwd_sel_b == 2'b10) || mem_wr_reg);
        p_mem_load_never_r8: assert (!mem_is_load || (fwd_sel_a != 2'b10 && fwd_sel_b != 2'b10));
        p_wb_needs_wr_r2: assert (!(fwd_sel_a == 2'b01 || fwd_sel_b == 2'b01) || wb_wr_reg);
        p_zero_no_fwd_r4: assert (ex_rs != '0 || fwd_sel_a == 2'b00);
        p_st_needs_enables_r5: assert (!st_fwd_sel || (mem_is_store && wb_wr_reg && wb_dst != '0));
        p_stall_fanout_r6: assert (stall_fetch == stall_decode && stall_decode == flush_execute);
        p_stall_needs_load_r6: assert (!stall_fetch || (ex_is_load && ex_dst != '0));
        p_store_data_exempt_r7: assert (!(dec_is_store && ex_dst == dec_rt && ex_dst != dec_rs) || !stall_fetch);
    end

endmodule

bind hzd_unit hzd_unit_chk #(.AW(AW)) u_chk (
    .dec_rs       (dec_rs),
    .dec_rt       (dec_rt),
    .dec_is_store (dec_is_store),
    .ex_rs        (ex_rs),
    .ex_dst       (ex_dst),
    .ex_is_load   (ex_is_load),
    .mem_wr_reg   (mem_wr_reg),
    .mem_is_load  (mem_is_load),
    .mem_is_store (mem_is_store),
    .wb_dst       (wb_dst),
    .wb_wr_reg    (wb_wr_reg),
    .fwd_sel_a    (fwd_sel_a),
    .fwd_sel_b    (fwd_sel_b),
    .st_fwd_sel   (st_fwd_sel),
    .stall_fetch  (stall_fetch),
    .stall_decode (stall_decode),
    .flush_execute(flush_execute)
);

// File: tb/tb_hzd_unit.sv
// Directed bench for hzd_unit: one task per scenario plus a random sweep
// checked against a reference model written from the requirements.
module tb_hzd_unit;

    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] dec_rs, dec_rt, ex_rs, ex_rt, ex_dst, mem_dst, mem_rt, wb_dst;
    logic dec_is_store, ex_is_load, mem_wr_reg, mem_is_load, mem_is_store, wb_wr_reg;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic st_fwd_sel, stall_fetch, stall_decode, flush_execute;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    hzd_unit #(.AW(AW)) dut (
        .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_is_store(dec_is_store),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_wr_reg(mem_wr_reg), .mem_is_load(mem_is_load),
        .mem_rt(mem_rt), .mem_is_store(mem_is_store),
        .wb_dst(wb_dst), .wb_wr_reg(wb_wr_reg),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .st_fwd_sel(st_fwd_sel),
        .stall_fetch(stall_fetch), .stall_decode(stall_decode), .flush_execute(flush_execute)
    );

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        dec_rs = '0; dec_rt = '0; dec_is_store = 0;
        ex_rs = '0; ex_rt = '0; ex_dst = '0; ex_is_load = 0;
        mem_dst = '0; mem_wr_reg = 0; mem_is_load = 0; mem_rt = '0; mem_is_store = 0;
        wb_dst = '0; wb_wr_reg = 0;
    endtask

    // Inputs change just after a rising edge; outputs are read at the falling edge.
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic drive_start();
        @(posedge clk); #1;
        idle();
    endtask

    // Reference model built from R1 to R8.
    function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
        if (s != 0 && mem_wr_reg && !mem_is_load && mem_dst == s) return 2'b10;
        if (s != 0 && wb_wr_reg && wb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic ref_st();
        return wb_wr_reg && mem_is_store && wb_dst != 0 && wb_dst == mem_rt;
    endfunction

    function automatic logic ref_stall();
        return ex_is_load && ex_dst != 0 &&
               (ex_dst == dec_rs || (ex_dst == dec_rt && !dec_is_store));
    endfunction

    task automatic t_reset_state();
        drive_start();
        settle();
        chk("R2", "idle sel_a", fwd_sel_a, 2'b00);
        chk("R2", "idle sel_b", fwd_sel_b, 2'b00);
        chk("R5", "idle st_fwd", {1'b0, st_fwd_sel}, 2'b00);
        chk("R6", "idle stall", {stall_fetch, flush_execute}, 2'b00);
    endtask

    task automatic t_mem_fwd_r1();
        drive_start();
        ex_rs = 5'd7; ex_rt = 5'd9; mem_dst = 5'd7; mem_wr_reg = 1;
        settle();
        chk("R1", "mem->A", fwd_sel_a, 2'b10);
        chk("R1", "B untouched", fwd_sel_b, 2'b00);
        mem_wr_reg = 0;
        settle();
        chk("R1", "mem wr off", fwd_sel_a, 2'b00);
    endtask

    task automatic t_wb_fwd_r2();
        drive_start();
        ex_rs = 5'd3; ex_rt = 5'd12; wb_dst = 5'd12; wb_wr_reg = 1;
        settle();
        chk("R2", "wb->B", fwd_sel_b, 2'b01);
        chk("R2", "A untouched", fwd_sel_a, 2'b00);
        wb_wr_reg = 0;
        settle();
        chk("R2", "wb wr off", fwd_sel_b, 2'b00);
    endtask

    task automatic t_priority_r3();
        drive_start();
        ex_rs = 5'd5; ex_rt = 5'd5; mem_dst = 5'd5; mem_wr_reg = 1; wb_dst = 5'd5; wb_wr_reg = 1;
        settle();
        chk("R3", "both A", fwd_sel_a, 2'b10);
        chk("R3", "both B", fwd_sel_b, 2'b10);
    endtask

    task automatic t_zero_r4();
        drive_start();
        mem_dst = 0; mem_wr_reg = 1; wb_dst = 0; wb_wr_reg = 1;
        mem_rt = 0; mem_is_store = 1; ex_dst = 0; ex_is_load = 1;
        settle();
        chk("R4", "zero A", fwd_sel_a, 2'b00);
        chk("R4", "zero B", fwd_sel_b, 2'b00);
        chk("R4", "zero st", {1'b0, st_fwd_sel}, 2'b00);
        chk("R4", "zero stall", {1'b0, stall_fetch}, 2'b00);
    endtask

    task automatic t_store_fwd_r5();
        drive_start();
        mem_rt = 5'd8; mem_is_store = 1; wb_dst = 5'd8; wb_wr_reg = 1;
        settle();
        chk("R5", "st match", {1'b0, st_fwd_sel}, 2'b01);
        wb_wr_reg = 0;
        settle();
        chk("R5", "st wb off", {1'b0, st_fwd_sel}, 2'b00);
        wb_wr_reg = 1; mem_is_store = 0;
        settle();
        chk("R5", "st not store", {1'b0, st_fwd_sel}, 2'b00);
        mem_is_store = 1; wb_dst = 5'd9;
        settle();
        chk("R5", "st mismatch", {1'b0, st_fwd_sel}, 2'b00);
    endtask

    task automatic t_load_use_r6();
        drive_start();
        ex_is_load = 1; ex_dst = 5'd4; dec_rs = 5'd4; dec_rt = 5'd1;
        settle();
        chk("R6", "rs use stall/dec", {stall_fetch, stall_decode}, 2'b11);
        chk("R6", "rs use flush", {1'b0, flush_execute}, 2'b01);
        dec_rs = 5'd2; dec_rt = 5'd4;
        settle();
        chk("R6", "rt use non-store", {stall_fetch, flush_execute}, 2'b11);
        ex_is_load = 0;
        settle();
        chk("R6", "no load", {stall_fetch, flush_execute}, 2'b00);
    endtask

    task automatic t_store_exempt_r7();
        drive_start();
        ex_is_load = 1; ex_dst = 5'd6; dec_rs = 5'd2; dec_rt = 5'd6; dec_is_store = 1;
        settle();
        chk("R7", "store data no stall", {stall_fetch, flush_execute}, 2'b00);
        dec_rs = 5'd6;
        settle();
        chk("R7", "store addr stalls", {stall_decode, flush_execute}, 2'b11);
    endtask

    task automatic t_mem_load_r8();
        drive_start();
        ex_rs = 5'd10; mem_dst = 5'd10; mem_wr_reg = 1; mem_is_load = 1;
        settle();
        chk("R8", "mem load skipped", fwd_sel_a, 2'b00);
        wb_dst = 5'd10; wb_wr_reg = 1;
        settle();
        chk("R8", "falls to wb", fwd_sel_a, 2'b01);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            dec_rs = AW'($urandom_range(0, 3)); dec_rt = AW'($urandom_range(0, 3));
            ex_rs = AW'($urandom_range(0, 3)); ex_rt = AW'($urandom_range(0, 3));
            ex_dst = AW'($urandom_range(0, 3)); mem_dst = AW'($urandom_range(0, 3));
            mem_rt = AW'($urandom_range(0, 3)); wb_dst = AW'($urandom_range(0, 3));
            dec_is_store = 1'($urandom); ex_is_load = 1'($urandom);
            mem_wr_reg = 1'($urandom); mem_is_load = 1'($urandom);
            mem_is_store = 1'($urandom); wb_wr_reg = 1'($urandom);
            settle();
            chk("R1", "rand sel_a", fwd_sel_a, ref_sel(ex_rs));
            chk("R3", "rand sel_b", fwd_sel_b, ref_sel(ex_rt));
            chk("R5", "rand st", {1'b0, st_fwd_sel}, {1'b0, ref_st()});
            chk("R6", "rand stall", {stall_fetch, flush_execute}, {2{ref_stall()}});
        end
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_mem_fwd_r1();
        t_wb_fwd_r2();
        t_priority_r3();
        t_zero_r4();
        t_store_fwd_r5();
        t_load_use_r6();
        t_store_exempt_r7();
        t_mem_load_r8();
        t_random();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule